// File: doc/BRIEF.md
# Masked Color-Key Overlay Selector

This block sits in the pixel path ahead of the palette lookup and the digital-to-analog converter. Every cycle it takes one frame-buffer pixel word and compares it, byte by byte, with a programmable 24-bit key. Each key byte has its own mask byte. A mask bit of 1 removes that pixel bit from the comparison, and a mask bit of 0 keeps it. When the comparison matches and the overlay is enabled, the block outputs the external live-video word in place of the frame-buffer pixel. The key-hit flag is reported in either case.

Which key bytes take part depends on the display color depth:

| Mode code | Enumerator | Color depth | Lanes compared |
|-----------|------------|-------------|----------------|
| `2'b00` | `DM_PAL8` | 4/8 bpp, palette index | lane 0 only |
| `2'b01` | `DM_RGB555` | 15 bpp | lanes 0 and 1 |
| `2'b11` | `DM_RGB565` | 16 bpp | lanes 0 and 1 |
| `2'b10` | `DM_RGB888` | 24 bpp | all three lanes |

A lane that the current mode does not use always counts as matched, whatever its mask holds. A mask left wrong by software therefore cannot block a hit.

The selected pixel, the key-hit flag and a pixel-valid qualifier all leave the block through a single register stage. The design has no multi-cycle control, so it has no state machine. The mode decoder is its only enumerated decision and it takes no cycles of its own.

Top module: `ckey_overlay_sel`

## Requirements
- R1: While `rst_n` is low, `pix_valid_o`, `key_hit_o` and `pix_data_o` are all 0.
- R2: `pix_valid_o` equals `pix_valid_i` delayed by exactly one clock cycle, and the pixel and flag outputs belong to the same input cycle.
- R3: A mask bit of 1 excludes the pixel bit at the same position from the comparison. A mask bit of 0 requires that pixel bit to equal the key bit.
- R4: Lane 0 compares pixel bits 7:0 with key bits 7:0 under mask bits 7:0. Lane 1 does the same over bits 15:8, and lane 2 over bits 23:16.
- R5: In mode code 2'b00, only lane 0 decides the hit. Differences in bits 23:8 are ignored even when their mask bits are 0.
- R6: In mode codes 2'b01 and 2'b11, lanes 0 and 1 decide the hit. Differences in bits 23:16 are ignored even when their mask bits are 0.
- R7: In mode code 2'b10, all three lanes must match for a hit.
- R8: When a valid pixel hits and `overlay_en_i` is 1, `pix_data_o` carries that cycle's `ext_video_i`. When a valid pixel misses, `pix_data_o` carries `pix_data_i`.
- R9: When `overlay_en_i` is 0, `pix_data_o` always carries `pix_data_i`, and `key_hit_o` still reports the comparison result.
- R10: `key_hit_o` is 0 whenever `pix_valid_o` is 0, and an invalid pixel is never replaced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid_i | input | 1 | Input pixel qualifier |
| pix_data_i | input | 24 | Frame-buffer pixel word, taken before the palette |
| depth_mode_i | input | 2 | Color-depth mode code |
| key_data_i | input | 24 | Key bytes; byte n sits at bits 8n+7:8n |
| key_mask_i | input | 24 | Mask bytes; 1 means ignore the bit |
| overlay_en_i | input | 1 | Enables replacement of the pixel on a key hit |
| ext_video_i | input | 24 | External live-video word |
| pix_valid_o | output | 1 | Output pixel qualifier, one cycle later |
| pix_data_o | output | 24 | Selected pixel |
| key_hit_o | output | 1 | Key comparison matched for a valid pixel |

## Verification
The bench builds the block with its default parameters: three lanes of eight bits, which gives the 24-bit key. At this width every lane boundary is reachable, so a single differing bit can be placed in each byte in turn under every mode code. This shows that lanes a mode leaves out are ignored even with an all-zero mask. A back-to-back stream with changing modes and enables checks that each output belongs to the input of the cycle before.

// File: rtl/ckey_pkg.sv
package ckey_pkg;

    // Color-depth mode codes (the encoding is part of the interface)
    typedef enum logic [1:0] {
        DM_PAL8   = 2'b00,
        DM_RGB555 = 2'b01,
        DM_RGB888 = 2'b10,
        DM_RGB565 = 2'b11
    } depth_mode_e;

    // Number of low-order lanes that take part in the compare for a mode
    function automatic int unsigned active_lanes(depth_mode_e m, int unsigned lanes);
        int unsigned n;
        unique case (m)
            DM_PAL8:   n = 1;
            DM_RGB555: n = 2;
            DM_RGB565: n = 2;
            DM_RGB888: n = 3;
            default:   n = 1;
        endcase
        return (n > lanes) ? lanes : n;
    endfunction

endpackage

// File: rtl/ckey_lane_select.sv
module ckey_lane_select
    import ckey_pkg::*;
#(
    parameter int unsigned LANES = 3
) (
    input  depth_mode_e      mode_i,
    output logic [LANES-1:0] lane_used_o
);

    int unsigned n_active;

    always_comb begin
        n_active = active_lanes(mode_i, LANES);
        for (int i = 0; i < LANES; i++) begin
            lane_used_o[i] = (i < n_active);
        end
    end

endmodule

// File: rtl/ckey_lane.sv
module ckey_lane #(
    parameter int unsigned LANE_W = 8
) (
    input  logic [LANE_W-1:0] pix_i,
    input  logic [LANE_W-1:0] key_i,
    input  logic [LANE_W-1:0] mask_i,
    input  logic              used_i,
    output logic              match_o
);

    logic [LANE_W-1:0] diff_bits;

    always_comb begin
        diff_bits = (pix_i ^ key_i) & ~mask_i;
        match_o   = !used_i || (diff_bits == '0);
    end

endmodule

// File: rtl/ckey_overlay_sel.sv
module ckey_overlay_sel
    import ckey_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 3,
    localparam int unsigned PIX_W = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid_i,
    input  logic [PIX_W-1:0] pix_data_i,
    input  logic [1:0]       depth_mode_i,
    input  logic [PIX_W-1:0] key_data_i,
    input  logic [PIX_W-1:0] key_mask_i,
    input  logic             overlay_en_i,
    input  logic [PIX_W-1:0] ext_video_i,
    output logic             pix_valid_o,
    output logic [PIX_W-1:0] pix_data_o,
    output logic             key_hit_o
);

    depth_mode_e      mode;
    logic [LANES-1:0] lane_used;
    logic [LANES-1:0] lane_match;
    logic             hit_nxt;
    logic [PIX_W-1:0] data_nxt;

    assign mode = depth_mode_e'(depth_mode_i);

    ckey_lane_select #(.LANES(LANES)) sel_i (
        .mode_i      (mode),
        .lane_used_o (lane_used)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ckey_lane #(.LANE_W(LANE_W)) lane_i (
            .pix_i   (pix_data_i[g*LANE_W +: LANE_W]),
            .key_i   (key_data_i[g*LANE_W +: LANE_W]),
            .mask_i  (key_mask_i[g*LANE_W +: LANE_W]),
            .used_i  (lane_used[g]),
            .match_o (lane_match[g])
        );
    end

    // Next-value selection
    always_comb begin
        hit_nxt  = pix_valid_i && (&lane_match);
        data_nxt = (hit_nxt && overlay_en_i) ? ext_video_i : pix_data_i;
    end

    // Output stage register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_valid_o <= 1'b0;
            key_hit_o   <= 1'b0;
            pix_data_o  <= '0;
        end else begin
            pix_valid_o <= pix_valid_i;
            key_hit_o   <= hit_nxt;
            pix_data_o  <= data_nxt;
        end
    end

endmodule

// File: rtl/ckey_overlay_sel_chk.sv
module ckey_overlay_sel_chk #(
    parameter int unsigned PIX_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid_i,
    input logic [PIX_W-1:0] pix_data_i,
    input logic [PIX_W-1:0] key_mask_i,
    input logic             overlay_en_i,
    input logic [PIX_W-1:0] ext_video_i,
    input logic             pix_valid_o,
    input logic [PIX_W-1:0] pix_data_o,
    input logic             key_hit_o
);

    // R2: qualifier delayed by one cycle
    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> pix_valid_o);
    p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> !pix_valid_o);

    // R10: no hit without a valid pixel
    p_hit_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit_o |-> pix_valid_o);

    // R3: a fully masked key always hits a valid pixel
    p_full_mask_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && (&key_mask_i)) |=> key_hit_o);

    // R9: overlay disabled means pass-through
    p_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !overlay_en_i |=> (pix_data_o == $past(pix_data_i)));

    // R8: with overlay enabled, the output follows the hit flag
    p_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overlay_en_i |=> (pix_data_o == (key_hit_o ? $past(ext_video_i) : $past(pix_data_i))));

    // R1: reset values
    always @(posedge clk) begin
        if (!rst_n) begin
            a_reset_r1: assert (!pix_valid_o && !key_hit_o && pix_data_o == '0);
        end
    end

endmodule

bind ckey_overlay_sel ckey_overlay_sel_chk #(.PIX_W(PIX_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_valid_i  (pix_valid_i),
    .pix_data_i   (pix_data_i),
    .key_mask_i   (key_mask_i),
    .overlay_en_i (overlay_en_i),
    .ext_video_i  (ext_video_i),
    .pix_valid_o  (pix_valid_o),
    .pix_data_o   (pix_data_o),
    .key_hit_o    (key_hit_o)
);

// File: tb/ckey_overlay_sel_tb.sv
module ckey_overlay_sel_tb_top;

    localparam int PW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_valid_i = 1'b0;
    logic [PW-1:0] pix_data_i = '0;
    logic [1:0]    depth_mode_i = 2'b00;
    logic [PW-1:0] key_data_i = '0;
    logic [PW-1:0] key_mask_i = '0;
    logic          overlay_en_i = 1'b0;
    logic [PW-1:0] ext_video_i = '0;
    logic          pix_valid_o;
    logic [PW-1:0] pix_data_o;
    logic          key_hit_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ckey_overlay_sel dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pix_valid_i  (pix_valid_i),
        .pix_data_i   (pix_data_i),
        .depth_mode_i (depth_mode_i),
        .key_data_i   (key_data_i),
        .key_mask_i   (key_mask_i),
        .overlay_en_i (overlay_en_i),
        .ext_video_i  (ext_video_i),
        .pix_valid_o  (pix_valid_o),
        .pix_data_o   (pix_data_o),
        .key_hit_o    (key_hit_o)
    );

    // Reference, written from R3-R7
    function automatic bit ref_hit(logic [PW-1:0] p, logic [PW-1:0] k,
                                   logic [PW-1:0] m, logic [1:0] md);
        logic [PW-1:0] d;
        d = (p ^ k) & ~m;
        case (md)
            2'b00:   return d[7:0] == 8'h00;
            2'b01,
            2'b11:   return d[15:0] == 16'h0000;
            default: return d == '0;
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [PW-1:0] act, logic [PW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one pixel and check it one cycle later
    task automatic run_pixel(string req, bit v, logic [1:0] md, logic [PW-1:0] p,
                             logic [PW-1:0] k, logic [PW-1:0] m, bit en,
                             logic [PW-1:0] ext);
        bit            eh;
        logic [PW-1:0] ed;
        @(negedge clk);
        pix_valid_i = v; depth_mode_i = md; pix_data_i = p;
        key_data_i = k; key_mask_i = m; overlay_en_i = en; ext_video_i = ext;
        eh = v && ref_hit(p, k, m, md);
        ed = (eh && en) ? ext : p;
        @(negedge clk);
        check(pix_valid_o == v, {req, " valid"}, PW'(pix_valid_o), PW'(v));
        check(key_hit_o == eh, {req, " hit"}, PW'(key_hit_o), PW'(eh));
        check(pix_data_o == ed, {req, " data"}, pix_data_o, ed);
        pix_valid_i = 1'b0;
    endtask

    task automatic t_reset_r1();
        rst_n = 1'b0;
        pix_valid_i = 1'b1; pix_data_i = 24'hABCDEF; overlay_en_i = 1'b1;
        key_mask_i = '1;
        repeat (3) @(negedge clk);
        check(!pix_valid_o, "R1 valid", PW'(pix_valid_o), '0);
        check(!key_hit_o, "R1 hit", PW'(key_hit_o), '0);
        check(pix_data_o == '0, "R1 data", pix_data_o, '0);
        pix_valid_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_full_match_r7();
        run_pixel("R7 exact", 1, 2'b10, 24'h123456, 24'h123456, 24'h0, 1, 24'hC0FFEE);
        run_pixel("R7 byte2 diff", 1, 2'b10, 24'h923456, 24'h123456, 24'h0, 1, 24'hC0FFEE);
        run_pixel("R8 miss passes", 1, 2'b10, 24'h123457, 24'h123456, 24'h0, 1, 24'hC0FFEE);
    endtask

    task automatic t_mask_r3_r4();
        // one bit per lane differs, first masked then compared
        for (int ln = 0; ln < 3; ln++) begin
            logic [PW-1:0] bitm;
            bitm = PW'(1) << (ln * 8 + 5);
            run_pixel("R3 R4 masked", 1, 2'b10, 24'h5A5A5A ^ bitm, 24'h5A5A5A, bitm, 1, 24'h010203);
            run_pixel("R3 R4 compared", 1, 2'b10, 24'h5A5A5A ^ bitm, 24'h5A5A5A,
                      ~bitm & 24'h0000FF, 1, 24'h010203);
        end
        run_pixel("R3 full mask", 1, 2'b10, 24'hFFFFFF, 24'h000000, 24'hFFFFFF, 1, 24'h777777);
    endtask

    task automatic t_pal8_r5();
        run_pixel("R5 upper ignored", 1, 2'b00, 24'hFFEE42, 24'h001142, 24'h0, 1, 24'hAAAAAA);
        run_pixel("R5 low differs", 1, 2'b00, 24'h001143, 24'h001142, 24'h0, 1, 24'hAAAAAA);
    endtask

    task automatic t_rgb16_r6();
        run_pixel("R6 555 byte2 ignored", 1, 2'b01, 24'hFF7C1F, 24'h007C1F, 24'h0, 1, 24'h0F0F0F);
        run_pixel("R6 565 byte2 ignored", 1, 2'b11, 24'h80F800, 24'h00F800, 24'h0, 1, 24'h0F0F0F);
        run_pixel("R6 565 byte1 differs", 1, 2'b11, 24'h00F900, 24'h00F800, 24'h0, 1, 24'h0F0F0F);
        run_pixel("R6 555 byte0 differs", 1, 2'b01, 24'h007C1E, 24'h007C1F, 24'h0, 1, 24'h0F0F0F);
    endtask

    task automatic t_overlay_off_r9();
        run_pixel("R9 hit no subst", 1, 2'b10, 24'h336699, 24'h336699, 24'h0, 0, 24'hDEAD00);
        run_pixel("R9 miss", 1, 2'b00, 24'h336698, 24'h336699, 24'h0, 0, 24'hDEAD00);
    endtask

    task automatic t_invalid_r10();
        run_pixel("R10 invalid", 0, 2'b10, 24'h111111, 24'h111111, 24'h0, 1, 24'h222222);
    endtask

    // Back-to-back stream: each output belongs to the input one cycle before
    task automatic t_stream_r2();
        bit            eh_prev = 0;
        bit            v_prev = 0;
        logic [PW-1:0] ed_prev = '0;
        for (int i = 0; i < 12; i++) begin
            logic [PW-1:0] p;
            logic [1:0]    md;
            bit            en;
            bit            v;
            @(negedge clk);
            if (i > 0) begin
                check(pix_valid_o == v_prev, "R2 stream valid", PW'(pix_valid_o), PW'(v_prev));
                check(key_hit_o == eh_prev, "R2 stream hit", PW'(key_hit_o), PW'(eh_prev));
                check(pix_data_o == ed_prev, "R2 stream data", pix_data_o, ed_prev);
            end
            p  = (i % 3 == 0) ? 24'h0A0B0C : 24'h0A0B0C ^ (PW'(1) << (i * 2));
            md = 2'(i);
            en = (i % 4) != 1;
            v  = (i % 5) != 2;
            pix_valid_i = v; pix_data_i = p; depth_mode_i = md;
            key_data_i = 24'h0A0B0C; key_mask_i = 24'h0; overlay_en_i = en;
            ext_video_i = 24'hE00000 | PW'(i);
            v_prev  = v;
            eh_prev = v && ref_hit(p, 24'h0A0B0C, 24'h0, md);
            ed_prev = (eh_prev && en) ? ext_video_i : p;
        end
        @(negedge clk);
        check(pix_data_o == ed_prev, "R2 stream last", pix_data_o, ed_prev);
        pix_valid_i = 1'b0;
    endtask

    initial begin
        t_reset_r1();
        t_full_match_r7();
        t_mask_r3_r4();
        t_pal8_r5();
        t_rgb16_r6();
        t_overlay_off_r9();
        t_invalid_r10();
        t_stream_r2();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule